// File: doc/BRIEF.md
# Complement-Method Subtractor

This block forms the difference A minus B of two unsigned N-bit operands by complement addition, in one of two arithmetic styles picked per operation. In the one's-complement style the subtrahend is inverted and summed with the minuend, and a carry out of the top bit is fed back into the low end. In the two's-complement style the inverted subtrahend is summed with an extra carry-in of one, and the top carry is dropped. In both styles the final carry decides the sign: a carry means the difference is non-negative.

A caller presents both operands and a style select together with a one-cycle strobe. The block captures the result at that clock edge and presents it on the next cycle with a valid flag. There are three outputs: a sign flag, a true-form magnitude, and a raw word that holds the difference in the chosen complement encoding. The outputs keep their value until the next strobe. Equal operands in the one's-complement style always come out as positive zero.

Top module: `csub_core`

## Requirements
- R1: On the cycle after a strobe, `res_neg` is 1 exactly when the captured A is less than the captured B.
- R2: On the cycle after a strobe, `res_mag` equals the absolute difference |A - B| as an N-bit unsigned value.
- R3: With `sel_twos` = 0 (one's-complement style) and A > B, `res_raw` equals A - B. With A < B, `res_raw` equals the bitwise inverse of B - A over N bits.
- R4: With `sel_twos` = 1 (two's-complement style), `res_raw` equals (A - B) modulo 2^N for every operand pair.
- R5: With `sel_twos` = 0 and A = B, the result is positive zero: `res_raw` is all zeros, `res_mag` is zero and `res_neg` is 0, never the all-ones negative zero.
- R6: `res_valid` is 1 in exactly the cycle after each cycle in which `in_strobe` is 1, and 0 after a cycle without a strobe. Back-to-back strobes give back-to-back results.
- R7: In a cycle without a strobe, changes on `opnd_a`, `opnd_b` and `sel_twos` have no effect: `res_neg`, `res_mag` and `res_raw` keep their last values.
- R8: While `rst_n` is 0, all outputs are held at zero, whatever the strobe and operands do.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_strobe | input | 1 | Capture request for operands and style select |
| sel_twos | input | 1 | Arithmetic style: 0 one's complement, 1 two's complement |
| opnd_a | input | N | Minuend A, unsigned |
| opnd_b | input | N | Subtrahend B, unsigned |
| res_valid | output | 1 | Result is fresh this cycle |
| res_neg | output | 1 | Difference is negative |
| res_mag | output | N | True-form magnitude of the difference |
| res_raw | output | N | Difference in the selected complement encoding |

## Verification
The bound checker checks on every cycle the timing of the valid flag and the agreement of sign and magnitude with an ordered compare of the operands captured one cycle earlier. It also checks that the raw word is the bitwise or arithmetic negation of the magnitude in the selected style, that equal operands in the one's-complement style never give negative zero, and that results hold between strobes. Only the bench's scenarios show that reset clears outputs which already hold a nonzero result, that the raw words match exact arithmetic expectations over an exhaustive operand sweep in both styles, and that the five-bit case of 7 minus 11 gives the expected encodings.

// File: rtl/csub_pkg.sv
package csub_pkg;

  // Arithmetic style carried on the select input
  typedef enum logic {
    STYLE_ONES = 1'b0,
    STYLE_TWOS = 1'b1
  } csub_style_e;

  // Result fields of one subtraction, before the output register
  typedef struct packed {
    logic neg;
    logic zero_fix;
  } csub_flags_t;

endpackage

// File: rtl/csub_adder.sv
module csub_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] add_x,
  input  logic [N-1:0] add_y,
  input  logic         add_cin,
  output logic [N-1:0] add_sum,
  output logic         add_cout
);

  localparam int CW = N + 1;

  logic [CW-1:0] chain;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  assign chain[0] = add_cin;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign add_sum[i]   = fa_sum(add_x[i], add_y[i], chain[i]);
    assign chain[i + 1] = fa_carry(add_x[i], add_y[i], chain[i]);
  end

  assign add_cout = chain[CW-1];

endmodule

// File: rtl/csub_ones_path.sv
module csub_ones_path #(
  parameter int N = 8
) (
  input  logic [N-1:0] pa,
  input  logic [N-1:0] pb,
  output logic [N-1:0] p_raw,
  output logic [N-1:0] p_mag,
  output logic         p_neg
);

  import csub_pkg::*;

  logic [N-1:0] inv_b;
  logic [N-1:0] sum_w;
  logic         carry_w;
  logic [N-1:0] eac_w;
  csub_flags_t  flags;

  // End-around correction: the top carry re-enters at bit zero
  function automatic logic [N-1:0] wrap_carry(input logic [N-1:0] s, input logic c);
    return s + {{(N-1){1'b0}}, c};
  endfunction

  assign inv_b = ~pb;

  csub_adder #(.N(N)) add_i (
    .add_x   (pa),
    .add_y   (inv_b),
    .add_cin (1'b0),
    .add_sum (sum_w),
    .add_cout(carry_w)
  );

  assign eac_w = wrap_carry(sum_w, carry_w);

  // All-ones sum without carry is negative zero; it is folded to plus zero
  assign flags.zero_fix = ~carry_w & (&sum_w);
  assign flags.neg      = ~carry_w & ~flags.zero_fix;

  always_comb begin
    if (carry_w) begin
      p_raw = eac_w;
      p_mag = eac_w;
    end else if (flags.zero_fix) begin
      p_raw = '0;
      p_mag = '0;
    end else begin
      p_raw = sum_w;
      p_mag = ~sum_w;
    end
  end

  assign p_neg = flags.neg;

endmodule

// File: rtl/csub_twos_path.sv
module csub_twos_path #(
  parameter int N = 8
) (
  input  logic [N-1:0] pa,
  input  logic [N-1:0] pb,
  output logic [N-1:0] p_raw,
  output logic [N-1:0] p_mag,
  output logic         p_neg
);

  logic [N-1:0] inv_b;
  logic [N-1:0] sum_w;
  logic         carry_w;

  // Two's negation: invert then add one
  function automatic logic [N-1:0] negate(input logic [N-1:0] v);
    return (~v) + {{(N-1){1'b0}}, 1'b1};
  endfunction

  assign inv_b = ~pb;

  // Carry-in of one supplies the increment; the carry out is only a sign
  csub_adder #(.N(N)) add_i (
    .add_x   (pa),
    .add_y   (inv_b),
    .add_cin (1'b1),
    .add_sum (sum_w),
    .add_cout(carry_w)
  );

  assign p_neg = ~carry_w;
  assign p_raw = sum_w;
  assign p_mag = carry_w ? sum_w : negate(sum_w);

endmodule

// File: rtl/csub_core.sv
module csub_core #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_strobe,
  input  logic         sel_twos,
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  output logic         res_valid,
  output logic         res_neg,
  output logic [N-1:0] res_mag,
  output logic [N-1:0] res_raw
);

  import csub_pkg::*;

  csub_style_e  style;
  logic [N-1:0] ones_raw, ones_mag;
  logic         ones_neg;
  logic [N-1:0] twos_raw, twos_mag;
  logic         twos_neg;
  logic [N-1:0] nxt_raw, nxt_mag;
  logic         nxt_neg;

  assign style = csub_style_e'(sel_twos);

  csub_ones_path #(.N(N)) ones_i (
    .pa   (opnd_a),
    .pb   (opnd_b),
    .p_raw(ones_raw),
    .p_mag(ones_mag),
    .p_neg(ones_neg)
  );

  csub_twos_path #(.N(N)) twos_i (
    .pa   (opnd_a),
    .pb   (opnd_b),
    .p_raw(twos_raw),
    .p_mag(twos_mag),
    .p_neg(twos_neg)
  );

  always_comb begin
    if (style == STYLE_TWOS) begin
      nxt_raw = twos_raw;
      nxt_mag = twos_mag;
      nxt_neg = twos_neg;
    end else begin
      nxt_raw = ones_raw;
      nxt_mag = ones_mag;
      nxt_neg = ones_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_neg   <= 1'b0;
      res_mag   <= '0;
      res_raw   <= '0;
    end else begin
      res_valid <= in_strobe;
      if (in_strobe) begin
        res_neg <= nxt_neg;
        res_mag <= nxt_mag;
        res_raw <= nxt_raw;
      end
    end
  end

endmodule

// File: rtl/csub_checker.sv
module csub_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_strobe,
  input logic         sel_twos,
  input logic [N-1:0] opnd_a,
  input logic [N-1:0] opnd_b,
  input logic         res_valid,
  input logic         res_neg,
  input logic [N-1:0] res_mag,
  input logic [N-1:0] res_raw
);

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> (res_neg == ($past(opnd_a) < $past(opnd_b))));

  p_mag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> (res_mag == (($past(opnd_a) >= $past(opnd_b)) ?
                               N'($past(opnd_a) - $past(opnd_b)) :
                               N'($past(opnd_b) - $past(opnd_a)))));

  p_ones_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !sel_twos) |=> (res_raw == (res_neg ? ~res_mag : res_mag)));

  p_twos_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && sel_twos) |=> (N'(res_raw + (res_neg ? res_mag : N'(~res_mag + 1'b1))) == '0));

  p_no_negzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !sel_twos && (opnd_a == opnd_b)) |=> (!res_neg && (res_raw == '0)));

  p_neg_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_neg |-> (res_mag != '0));

  p_valid_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> res_valid);

  p_valid_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_strobe |=> !res_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_strobe |=> ($stable(res_neg) && $stable(res_mag) && $stable(res_raw)));

endmodule

bind csub_core csub_checker #(.N(N)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_strobe(in_strobe),
  .sel_twos (sel_twos),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .res_valid(res_valid),
  .res_neg  (res_neg),
  .res_mag  (res_mag),
  .res_raw  (res_raw)
);

// File: tb/csub_core_tb_top.sv
`timescale 1ns/1ps
module csub_core_tb_top;

  localparam int W = 5;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_strobe;
  logic         sel_twos;
  logic [W-1:0] opnd_a, opnd_b;
  logic         res_valid, res_neg;
  logic [W-1:0] res_mag, res_raw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csub_core #(.N(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_strobe(in_strobe),
    .sel_twos (sel_twos),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .res_valid(res_valid),
    .res_neg  (res_neg),
    .res_mag  (res_mag),
    .res_raw  (res_raw)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values from plain integer arithmetic
  task automatic check_result(input int a, input int b, input int m);
    int diff, mag, raw;
    bit neg;
    diff = a - b;
    neg  = (a < b);
    mag  = neg ? -diff : diff;
    if (m == 1) raw = diff & (SPAN - 1);
    else        raw = neg ? ((SPAN - 1) - mag) : mag;
    check_eq("R6 valid after strobe", int'(res_valid), 1);
    check_eq("R1 sign", int'(res_neg), int'(neg));
    check_eq("R2 magnitude", int'(res_mag), mag);
    if (m == 1)      check_eq("R4 twos raw", int'(res_raw), raw);
    else if (a == b) check_eq("R5 plus zero raw", int'(res_raw), 0);
    else             check_eq("R3 ones raw", int'(res_raw), raw);
  endtask

  task automatic strobe(input int a, input int b, input int m);
    in_strobe = 1'b1;
    opnd_a    = W'(a);
    opnd_b    = W'(b);
    sel_twos  = m[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pa, pb, pm;
    bit have;
    rst_n = 1'b0;
    strobe(3, 9, 1);
    repeat (3) @(negedge clk);
    // R8: reset dominates an active strobe
    check_eq("R8 valid in reset", int'(res_valid), 0);
    check_eq("R8 raw in reset", int'(res_raw), 0);
    check_eq("R8 mag in reset", int'(res_mag), 0);
    check_eq("R8 sign in reset", int'(res_neg), 0);
    in_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R6 idle after reset", int'(res_valid), 0);

    // Directed: 7 minus 11 in both styles
    strobe(7, 11, 1);
    @(negedge clk);
    check_eq("R4 7-11 twos raw", int'(res_raw), 28);
    check_eq("R1 7-11 sign", int'(res_neg), 1);
    check_eq("R2 7-11 mag", int'(res_mag), 4);
    strobe(7, 11, 0);
    @(negedge clk);
    check_eq("R3 7-11 ones raw", int'(res_raw), 27);
    check_eq("R2 7-11 ones mag", int'(res_mag), 4);
    strobe(19, 19, 0);
    @(negedge clk);
    check_result(19, 19, 0);

    // Exhaustive sweep, one strobe per cycle
    have = 0;
    pa = 0; pb = 0; pm = 0;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          strobe(a, b, m);
          @(negedge clk);
          if (have) begin end
          check_result(a, b, m);
          have = 1;
          pa = a; pb = b; pm = m;
        end
      end
    end

    // R7: operands and style move without a strobe; outputs hold
    strobe(25, 6, 0);
    @(negedge clk);
    check_result(25, 6, 0);
    in_strobe = 1'b0;
    opnd_a = W'(2);
    opnd_b = W'(30);
    sel_twos = 1'b1;
    @(negedge clk);
    check_eq("R6 no strobe no valid", int'(res_valid), 0);
    check_eq("R7 hold raw", int'(res_raw), 19);
    check_eq("R7 hold mag", int'(res_mag), 19);
    check_eq("R7 hold sign", int'(res_neg), 0);
    @(negedge clk);
    check_eq("R7 hold raw later", int'(res_raw), 19);

    // R8: reset clears a held nonzero result
    strobe(1, 30, 1);
    @(negedge clk);
    check_result(1, 30, 1);
    in_strobe = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R8 mag cleared", int'(res_mag), 0);
    check_eq("R8 raw cleared", int'(res_raw), 0);
    check_eq("R8 sign cleared", int'(res_neg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule